// File: doc/BRIEF.md
# Registered ROM with Initialize Word

This block is a read-only word store whose output passes through an edge-triggered pipeline register. On every rising clock edge the word at the presented address moves into that register. The next address can then be decoded while the previous word stays steady on the outputs. A separate stored initialize word can be forced into the register at once, without a clock edge. This gives a known start value after power-up or a time-out, for example a fixed jump-start address in a microsequencer.

One active-low control pin has three possible meanings, chosen by a two-bit mode register. It can be an output enable that acts at once, an output enable that acts at the next clock edge, or the initialize input. When it is the initialize input, the outputs are always driven. The tri-state output is modelled as a data bus plus a drive flag. While the flag is low the bus reads as zero. A synchronous programming port loads the array, the initialize word and the mode register.

The array depth is set by `ADDR_W`. The full-size part uses 13 (8192 words). The default is 11 so that elaboration stays small.

Top module: `regrom_pipe`

## Requirements
- R1: While `rst_n` is low, every array word, the initialize word, the mode register and the pipeline register are cleared to zero. Mode 0 is enable-immediate.
- R2: At each rising clock edge the pipeline register takes the array word at `addr`. Changing `addr` between edges leaves `dout` unchanged until the next rising edge.
- R3: In mode 2'b00 (and the reserved 2'b11), `dout_vld` equals the inverse of `ctl_n` with no clock edge needed. Whenever `dout_vld` is 0, `dout` is 0.
- R4: In mode 2'b01, `dout_vld` changes only at a rising edge. It takes the inverse of the `ctl_n` value sampled at that edge.
- R5: In mode 2'b10, `dout_vld` is 1 at all times, whatever `ctl_n` is.
- R6: In mode 2'b10, driving `ctl_n` low puts the initialize word into the pipeline register and onto `dout` at once, with no clock edge.
- R7: While `ctl_n` is held low in mode 2'b10, clock edges load no array word. After `ctl_n` returns high, `dout` keeps the initialize word until the next rising edge, which loads the array word at `addr`.
- R8: An initialize word of 8'h00 clears the register. An initialize word of 8'hFF presets every output bit to 1.
- R9: When `prog_we` is high at a rising edge, the target selected by `prog_tgt` takes `prog_data`. The targets are 2'b00 for the array word at `prog_addr`, 2'b01 for the initialize word, and 2'b10 for the mode register (from `prog_data[1:0]`). Code 2'b11 writes nothing.
- R10: A write to the array word being read, at the same edge, lets the pipeline register capture the old word. The new word appears only after the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline and programming clock |
| rst_n | input | 1 | Active-low asynchronous reset of all storage |
| addr | input | ADDR_W | Read address |
| ctl_n | input | 1 | Shared active-low pin: output enable or initialize |
| prog_we | input | 1 | Programming write strobe |
| prog_tgt | input | 2 | Programming target select |
| prog_addr | input | ADDR_W | Array address for programming writes |
| prog_data | input | DATA_W | Programming write data |
| dout | output | DATA_W | Registered data, zero when not driven |
| dout_vld | output | 1 | High when the outputs are driven, low for high impedance |

## Verification
A programming write and a pipeline read can hit the same array word at the same rising edge. The bench provokes this by holding `addr` on a word while it strobes a new value into that same word in the same cycle. It expects the old word after that edge and the new word only after the next edge. The bench also holds the initialize input low across several edges while it changes the address, and judges that the clock stays blocked until release.

// File: rtl/rgp_pkg.sv
package rgp_pkg;

  typedef enum logic [1:0] {
    PT_ARRAY = 2'b00,
    PT_INIT  = 2'b01,
    PT_CFG   = 2'b10,
    PT_NONE  = 2'b11
  } prog_tgt_e;

  typedef enum logic [1:0] {
    PM_EN_ASYNC = 2'b00,
    PM_EN_SYNC  = 2'b01,
    PM_INIT     = 2'b10,
    PM_RSVD     = 2'b11
  } pin_mode_e;

  // Reserved code behaves as the immediate enable.
  function automatic pin_mode_e decode_mode(input logic [1:0] cfg);
    case (cfg)
      2'b01:   return PM_EN_SYNC;
      2'b10:   return PM_INIT;
      default: return PM_EN_ASYNC;
    endcase
  endfunction

  function automatic logic init_request(input pin_mode_e m, input logic pin_n);
    return (m == PM_INIT) && !pin_n;
  endfunction

  function automatic logic drive_flag(input pin_mode_e m, input logic pin_n,
                                      input logic en_sampled);
    case (m)
      PM_INIT:    return 1'b1;
      PM_EN_SYNC: return en_sampled;
      default:    return !pin_n;
    endcase
  endfunction

endpackage

// File: rtl/rgp_store.sv
module rgp_store import rgp_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [1:0]        prog_tgt,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] init_word,
  output logic [1:0]        cfg_bits
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic wr_array, wr_init, wr_cfg;

  assign wr_array = prog_we && (prog_tgt == PT_ARRAY);
  assign wr_init  = prog_we && (prog_tgt == PT_INIT);
  assign wr_cfg   = prog_we && (prog_tgt == PT_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_array) begin
      mem[prog_addr] <= prog_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_word <= '0;
      cfg_bits  <= '0;
    end else begin
      if (wr_init) init_word <= prog_data;
      if (wr_cfg)  cfg_bits  <= prog_data[1:0];
    end
  end

  assign rd_word = mem[rd_addr];

endmodule

// File: rtl/rgp_outreg.sv
module rgp_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic [DATA_W-1:0] init_word,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] q
);
  logic load_n;

  assign load_n = rst_n & ~init_req;

  // Asynchronous load path: reset clears, an initialize request loads the
  // stored word and keeps reloading it at every edge while it is held.
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) q <= rst_n ? init_word : '0;
    else         q <= rd_word;
  end

endmodule

// File: rtl/rgp_oe.sv
module rgp_oe import rgp_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode,
  input  logic      ctl_n,
  output logic      vld
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= !ctl_n;
  end

  assign vld = drive_flag(mode, ctl_n, en_q);

endmodule

// File: rtl/regrom_pipe.sv
module regrom_pipe import rgp_pkg::*; #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ctl_n,
  input  logic              prog_we,
  input  logic [1:0]        prog_tgt,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] init_word;
  logic [1:0]        cfg_bits;
  logic [DATA_W-1:0] pipe_q;
  logic              init_req;
  pin_mode_e         mode;

  rgp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_tgt(prog_tgt),
    .prog_addr(prog_addr), .prog_data(prog_data), .rd_addr(addr),
    .rd_word(rd_word), .init_word(init_word), .cfg_bits(cfg_bits)
  );

  assign mode     = decode_mode(cfg_bits);
  assign init_req = init_request(mode, ctl_n);

  rgp_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_word(init_word),
    .rd_word(rd_word), .q(pipe_q)
  );

  rgp_oe u_oe (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ctl_n(ctl_n), .vld(dout_vld)
  );

  assign dout = dout_vld ? pipe_q : '0;

endmodule

// File: rtl/rgp_chk.sv
module rgp_chk import rgp_pkg::*; #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_n,
  input logic              prog_we,
  input logic [1:0]        prog_tgt,
  input logic [DATA_W-1:0] prog_data,
  input pin_mode_e         mode,
  input logic [1:0]        cfg_bits,
  input logic              init_req,
  input logic [DATA_W-1:0] init_word,
  input logic [DATA_W-1:0] pipe_q,
  input logic [DATA_W-1:0] dout,
  input logic              dout_vld
);

  p_async_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_EN_ASYNC) |-> (dout_vld == !ctl_n));

  p_off_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> (dout == '0));

  p_sync_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_EN_SYNC && $past(mode) == PM_EN_SYNC)
      |-> (dout_vld == !$past(ctl_n)));

  p_init_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_INIT) |-> dout_vld);

  p_init_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && $past(init_req) && $stable(init_word)) |-> (pipe_q == init_word));

  p_cfg_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && prog_tgt == PT_CFG) |=> (cfg_bits == $past(prog_data[1:0])));

  p_init_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && prog_tgt == PT_INIT) |=> (init_word == $past(prog_data)));

endmodule

bind regrom_pipe rgp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_n(ctl_n), .prog_we(prog_we),
  .prog_tgt(prog_tgt), .prog_data(prog_data), .mode(mode),
  .cfg_bits(cfg_bits), .init_req(init_req), .init_word(init_word),
  .pipe_q(pipe_q), .dout(dout), .dout_vld(dout_vld)
);

// File: tb/test_regrom_pipe.sv
module test_regrom_pipe;
  localparam int PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ctl_n = 1'b1;
  logic          prog_we = 1'b0;
  logic [1:0]    prog_tgt = 2'b00;
  logic [AW-1:0] prog_addr = '0;
  logic [DW-1:0] prog_data = '0;
  logic [DW-1:0] dout;
  logic          dout_vld;

  int n_chk = 0;
  int n_bad = 0;

  regrom_pipe #(.ADDR_W(AW), .DATA_W(DW)) i_regrom_pipe (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ctl_n(ctl_n),
    .prog_we(prog_we), .prog_tgt(prog_tgt), .prog_addr(prog_addr),
    .prog_data(prog_data), .dout(dout), .dout_vld(dout_vld)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 29) % 256) ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prog(input logic [1:0] tgt, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_tgt = tgt; prog_addr = AW'(a); prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ctl_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vld in reset", DW'(dout_vld), 8'h00);
    chk("R1 dout in reset", dout, 8'h00);
    @(negedge clk); rst_n = 1'b1; ctl_n = 1'b0;
    #1;
    chk("R1 vld enabled mode0", DW'(dout_vld), 8'h01);
    @(posedge clk); #1;
    chk("R1 array cleared", dout, 8'h00);
  endtask

  task automatic t_load;
    for (int i = 0; i < 16; i++) prog(2'b00, i, pat(i));
    addr = AW'(3);
    @(posedge clk); #1;
    chk("R9/R2 read word 3", dout, pat(3));
    @(negedge clk); addr = AW'(7); #1;
    chk("R2 stable between edges", dout, pat(3));
    @(posedge clk); #1;
    chk("R2 read word 7", dout, pat(7));
  endtask

  task automatic t_async_en;
    @(negedge clk); ctl_n = 1'b1; #1;
    chk("R3 off vld", DW'(dout_vld), 8'h00);
    chk("R3 off dout zero", dout, 8'h00);
    #2 ctl_n = 1'b0; #1;
    chk("R3 back on", dout, pat(7));
  endtask

  task automatic t_sync_en;
    prog(2'b10, 0, 8'h01);
    ctl_n = 1'b1; #1;
    chk("R4 no change before edge", DW'(dout_vld), 8'h01);
    @(posedge clk); #1;
    chk("R4 off at edge", DW'(dout_vld), 8'h00);
    @(negedge clk); ctl_n = 1'b0; #1;
    chk("R4 still off", DW'(dout_vld), 8'h00);
    @(posedge clk); #1;
    chk("R4 on at edge", dout, pat(7));
  endtask

  task automatic t_init_clear;
    @(negedge clk); ctl_n = 1'b1;
    prog(2'b10, 0, 8'h02);
    #1;
    chk("R5 driven with pin high", DW'(dout_vld), 8'h01);
    chk("R5 data kept", dout, pat(7));
    ctl_n = 1'b0; #1;
    chk("R8 clear with blank word", dout, 8'h00);
    @(negedge clk); ctl_n = 1'b1;
    @(posedge clk); #1;
    chk("R7 reload after clear", dout, pat(7));
  endtask

  task automatic t_init_word;
    prog(2'b01, 0, 8'hA5);
    ctl_n = 1'b0; #1;
    chk("R6 immediate load", dout, 8'hA5);
    addr = AW'(9);
    repeat (2) @(posedge clk);
    #1;
    chk("R7 clock blocked", dout, 8'hA5);
    chk("R5 driven during init", DW'(dout_vld), 8'h01);
    @(negedge clk); ctl_n = 1'b1; #1;
    chk("R7 held after release", dout, 8'hA5);
    @(posedge clk); #1;
    chk("R7 resumes load", dout, pat(9));
    prog(2'b01, 0, 8'hFF);
    ctl_n = 1'b0; #1;
    chk("R8 preset", dout, 8'hFF);
    @(negedge clk); ctl_n = 1'b1;
  endtask

  task automatic t_collide;
    prog(2'b10, 0, 8'h00);
    ctl_n = 1'b0; addr = AW'(12);
    @(posedge clk); #1;
    chk("R10 before write", dout, pat(12));
    @(negedge clk);
    prog_we = 1'b1; prog_tgt = 2'b00; prog_addr = AW'(12); prog_data = 8'h3C;
    @(posedge clk); #1;
    chk("R10 old word same edge", dout, pat(12));
    @(negedge clk); prog_we = 1'b0;
    @(posedge clk); #1;
    chk("R10 new word next edge", dout, 8'h3C);
    prog(2'b11, 12, 8'h77);
    @(posedge clk); #1;
    chk("R9 code 3 writes nothing", dout, 8'h3C);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_async_en();
    t_sync_en();
    t_init_clear();
    t_init_word();
    t_collide();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule